// File: doc/BRIEF.md
# External Bus Chip-Select and Wait-State Controller

This block sits between an internal requester and an external memory bus with a 24-bit byte address. It maps the 16 MB external space onto eight independent, active-low chip-select lines. Each select owns a window described by a base and a don't-care mask, both counted in 64 KB pages, plus an enable bit. When a request arrives, the block decodes the address and latches the result. It then runs one external cycle. The cycle has an address phase followed by a strobe phase, which gives a two-clock minimum.

The strobe phase is lengthened by a wait count of 0 to 15 clocks, chosen per window. After those waits have run out, the phase keeps extending for as long as the external device holds the ready input low. Each window also selects an 8-bit or a 16-bit data path, and this choice sets which byte-lane write strobes fire and how read data is aligned. Eight configuration words, one per window, are written and read back through a simple register port.

Top module: `xbus_select_ctrl`

## Requirements
- R1: After reset all chip selects, the read strobe and both write strobes are high, busy and done are low, and every configuration word reads zero.
- R2: A configuration word written at index i reads back unchanged. Its layout is base page in [7:0], mask page in [15:8], wait count in [19:16], 16-bit path in bit 24 and enable in bit 31. All other bits read zero.
- R3: A window matches when the address page addr[23:16] equals the base page in every bit where the mask is 0. Only the matching select goes low, and it stays low for the whole cycle.
- R4: When several enabled windows match, only the lowest-numbered one is asserted.
- R5: A disabled window never asserts its select, and enabling it later makes it respond.
- R6: An address matching no enabled window asserts no select and no strobe. The cycle lasts two clocks whatever the ready input does, and a read returns 0.
- R7: With zero waits and ready high, busy is high for exactly two clocks, and done pulses in the following clock.
- R8: A matched cycle lasts 2 plus the window's wait count clocks when ready is high.
- R9: Ready is ignored while programmed waits remain. After that, the cycle ends on the first clock in which ready is high. If ready is low for the first L busy clocks, the length is max(2+W, L+1).
- R10: In a 16-bit window, write lane enables are active-low: wr_n[0] drives bits 7:0 and wr_n[1] drives bits 15:8. A byte write at an even address drives only lane 0, a byte write at an odd address drives only lane 1, and a halfword write drives both. Byte data is replicated on both lanes.
- R11: In an 8-bit window, every write uses only lane 0 with the low data byte replicated. A read returns the low input byte, zero-extended.
- R12: A read in a 16-bit window asserts only rd_n. A halfword read returns all 16 input bits. A byte read returns the addressed lane, zero-extended.
- R13: At most one select is low in any clock, and the external address is stable for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_idx | input | 3 | Window index for write and read |
| cfg_wdata | input | 32 | Configuration write word |
| cfg_rdata | output | 32 | Configuration word at cfg_idx |
| req_valid | input | 1 | Start a cycle (taken only when not busy) |
| req_addr | input | 24 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_half | input | 1 | 1 = halfword, 0 = byte |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | External cycle in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 16 | Aligned read data of the last read |
| ext_addr | output | 24 | External address |
| ext_cs_n | output | 8 | Active-low chip selects |
| ext_rd_n | output | 1 | Active-low read strobe |
| ext_wr_n | output | 2 | Active-low byte-lane write strobes |
| ext_dout | output | 16 | External write data |
| ext_din | input | 16 | External read data |
| ext_rdy | input | 1 | External ready, high = ready |

## Verification
A wrong wait counter or phase register shows up at the busy length and the done pulse within the same access. This happens only once waits have run out, because ready is not looked at before then. Ready patterns shorter and longer than the wait count therefore separate the two. A decode or priority fault shows up in the first clock of the cycle as the wrong select or as two selects low together. A lane or alignment fault appears in the strobe-phase write enables, or in the read data in the clock done pulses.

// File: rtl/xbs_pkg.sv
package xbs_pkg;

    localparam int ADDR_W  = 24;
    localparam int GRAN_W  = 16;
    localparam int PAGE_W  = ADDR_W - GRAN_W;
    localparam int NSEL    = 8;
    localparam int SEL_W   = $clog2(NSEL);
    localparam int WAIT_W  = 4;
    localparam int DATA_W  = 16;
    localparam int LANES   = DATA_W / 8;
    localparam int CFG_W   = 32;

    // configuration word layout
    localparam int BASE_LSB = 0;
    localparam int MASK_LSB = 8;
    localparam int WAIT_LSB = 16;
    localparam int WIDE_BIT = 24;
    localparam int EN_BIT   = 31;

    typedef struct packed {
        logic              en;
        logic              wide;
        logic [WAIT_W-1:0] waits;
        logic [PAGE_W-1:0] mask;
        logic [PAGE_W-1:0] base;
    } region_t;

    typedef struct packed {
        logic              write;
        logic              half;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } xfer_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_t;

    function automatic region_t word_to_region(input logic [CFG_W-1:0] w);
        region_t r;
        r.base  = w[BASE_LSB +: PAGE_W];
        r.mask  = w[MASK_LSB +: PAGE_W];
        r.waits = w[WAIT_LSB +: WAIT_W];
        r.wide  = w[WIDE_BIT];
        r.en    = w[EN_BIT];
        return r;
    endfunction

    function automatic logic [CFG_W-1:0] region_to_word(input region_t r);
        logic [CFG_W-1:0] w;
        w = '0;
        w[BASE_LSB +: PAGE_W] = r.base;
        w[MASK_LSB +: PAGE_W] = r.mask;
        w[WAIT_LSB +: WAIT_W] = r.waits;
        w[WIDE_BIT]           = r.wide;
        w[EN_BIT]             = r.en;
        return w;
    endfunction

    function automatic logic region_hit(input region_t r, input logic [PAGE_W-1:0] page);
        return r.en && (((page ^ r.base) & ~r.mask) == '0);
    endfunction

    // active-high byte-lane enables
    function automatic logic [LANES-1:0] lane_enables(input logic wide, input logic half,
                                                      input logic a0);
        if (!wide)     return 2'b01;
        else if (half) return 2'b11;
        else           return a0 ? 2'b10 : 2'b01;
    endfunction

    function automatic logic [DATA_W-1:0] align_read(input logic wide, input logic half,
                                                     input logic a0,
                                                     input logic [DATA_W-1:0] din);
        if (!wide)     return {8'h00, din[7:0]};
        else if (half) return din;
        else           return {8'h00, (a0 ? din[15:8] : din[7:0])};
    endfunction

    function automatic logic [DATA_W-1:0] align_write(input logic wide, input logic half,
                                                      input logic [DATA_W-1:0] wd);
        return (wide && half) ? wd : {wd[7:0], wd[7:0]};
    endfunction

endpackage

// File: rtl/xbs_cfg_regs.sv
module xbs_cfg_regs
    import xbs_pkg::*;
#(
    parameter int N = NSEL
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [SEL_W-1:0]     idx,
    input  logic [CFG_W-1:0]     wdata,
    output logic [CFG_W-1:0]     rdata,
    output region_t              regions [N]
);

    for (genvar g = 0; g < N; g++) begin : g_region
        always_ff @(posedge clk) begin
            if (rst) begin
                regions[g] <= '0;
            end else if (we && idx == SEL_W'(g)) begin
                regions[g] <= word_to_region(wdata);
            end
        end
    end

    always_comb begin
        rdata = region_to_word(regions[idx]);
    end

endmodule

// File: rtl/xbs_decoder.sv
module xbs_decoder
    import xbs_pkg::*;
#(
    parameter int N = NSEL
) (
    input  region_t              regions [N],
    input  logic [ADDR_W-1:0]    addr,
    output logic [N-1:0]         sel,
    output logic                 hit,
    output logic [WAIT_W-1:0]    waits,
    output logic                 wide
);

    logic [PAGE_W-1:0] page;
    logic [N-1:0]      match;

    assign page = addr[ADDR_W-1 -: PAGE_W];

    for (genvar g = 0; g < N; g++) begin : g_match
        assign match[g] = region_hit(regions[g], page);
    end

    // isolate lowest set bit: lowest index has priority
    assign sel = match & (~match + N'(1));
    assign hit = |match;

    always_comb begin
        waits = '0;
        wide  = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                waits = regions[i].waits;
                wide  = regions[i].wide;
            end
        end
    end

endmodule

// File: rtl/xbs_cycle_fsm.sv
module xbs_cycle_fsm
    import xbs_pkg::*;
#(
    parameter int N = NSEL
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  xfer_t                xfer_in,
    input  logic [N-1:0]         sel,
    input  logic                 hit,
    input  logic [WAIT_W-1:0]    waits,
    input  logic                 wide,
    input  logic                 ext_rdy,
    input  logic [DATA_W-1:0]    ext_din,
    output logic                 busy,
    output logic                 idle,
    output logic                 done,
    output logic [DATA_W-1:0]    rd_data,
    output logic [ADDR_W-1:0]    ext_addr,
    output logic [N-1:0]         ext_cs_n,
    output logic                 ext_rd_n,
    output logic [LANES-1:0]     ext_wr_n,
    output logic [DATA_W-1:0]    ext_dout
);

    phase_t             phase;
    xfer_t              xq;
    logic [N-1:0]       sel_q;
    logic               hit_q;
    logic               wide_q;
    logic [WAIT_W-1:0]  wcnt;
    logic               strobe;
    logic               finish;

    assign finish = (phase == PH_DATA) && (wcnt == '0) && (ext_rdy || !hit_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            xq      <= '0;
            sel_q   <= '0;
            hit_q   <= 1'b0;
            wide_q  <= 1'b0;
            wcnt    <= '0;
            done    <= 1'b0;
            rd_data <= '0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        xq     <= xfer_in;
                        sel_q  <= sel;
                        hit_q  <= hit;
                        wide_q <= wide;
                        wcnt   <= hit ? waits : '0;
                        phase  <= PH_ADDR;
                    end
                end
                PH_ADDR: begin
                    phase <= PH_DATA;
                end
                PH_DATA: begin
                    if (wcnt != '0) begin
                        wcnt <= wcnt - 1'b1;
                    end else if (finish) begin
                        phase <= PH_IDLE;
                        done  <= 1'b1;
                        if (!xq.write) begin
                            rd_data <= hit_q ? align_read(wide_q, xq.half, xq.addr[0], ext_din)
                                             : '0;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign idle     = (phase == PH_IDLE);
    assign busy     = !idle;
    assign strobe   = (phase == PH_DATA) && hit_q;
    assign ext_addr = xq.addr;
    assign ext_cs_n = idle ? '1 : ~sel_q;
    assign ext_rd_n = !(strobe && !xq.write);
    assign ext_wr_n = ~(lane_enables(wide_q, xq.half, xq.addr[0]) & {LANES{strobe && xq.write}});
    assign ext_dout = align_write(wide_q, xq.half, xq.wdata);

endmodule

// File: rtl/xbus_select_ctrl.sv
module xbus_select_ctrl
    import xbs_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_idx,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic                 req_valid,
    input  logic [23:0]          req_addr,
    input  logic                 req_write,
    input  logic                 req_half,
    input  logic [15:0]          req_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [15:0]          rd_data,
    output logic [23:0]          ext_addr,
    output logic [7:0]           ext_cs_n,
    output logic                 ext_rd_n,
    output logic [1:0]           ext_wr_n,
    output logic [15:0]          ext_dout,
    input  logic [15:0]          ext_din,
    input  logic                 ext_rdy
);

    region_t            regions [NSEL];
    logic [NSEL-1:0]    dec_sel;
    logic               dec_hit;
    logic [WAIT_W-1:0]  dec_waits;
    logic               dec_wide;
    logic               fsm_idle;
    xfer_t              xfer_in;

    assign xfer_in = '{write: req_write, half: req_half, addr: req_addr, wdata: req_wdata};

    xbs_cfg_regs #(.N(NSEL)) i_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we),
        .idx     (cfg_idx),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .regions (regions)
    );

    xbs_decoder #(.N(NSEL)) i_dec (
        .regions (regions),
        .addr    (req_addr),
        .sel     (dec_sel),
        .hit     (dec_hit),
        .waits   (dec_waits),
        .wide    (dec_wide)
    );

    xbs_cycle_fsm #(.N(NSEL)) i_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (req_valid && fsm_idle),
        .xfer_in  (xfer_in),
        .sel      (dec_sel),
        .hit      (dec_hit),
        .waits    (dec_waits),
        .wide     (dec_wide),
        .ext_rdy  (ext_rdy),
        .ext_din  (ext_din),
        .busy     (busy),
        .idle     (fsm_idle),
        .done     (done),
        .rd_data  (rd_data),
        .ext_addr (ext_addr),
        .ext_cs_n (ext_cs_n),
        .ext_rd_n (ext_rd_n),
        .ext_wr_n (ext_wr_n),
        .ext_dout (ext_dout)
    );

endmodule

// File: rtl/xbs_checker.sv
module xbs_checker (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic [23:0] ext_addr,
    input logic [7:0]  ext_cs_n,
    input logic        ext_rd_n,
    input logic [1:0]  ext_wr_n
);

    logic [5:0] low_len;

    always_ff @(posedge clk) begin
        if (rst)              low_len <= '0;
        else if (~&ext_cs_n)  low_len <= (low_len == 6'h3f) ? low_len : low_len + 1'b1;
        else                  low_len <= '0;
    end

    // R13: never two selects at once
    p_cs_onehot_r13: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~ext_cs_n));

    // R13: address held through a cycle
    p_addr_stable_r13: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(ext_addr));

    // R1: nothing driven outside a cycle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (&ext_cs_n && ext_rd_n && &ext_wr_n));

    // R12: read and write strobes exclusive
    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(!ext_rd_n && !(&ext_wr_n)));

    // R7: done follows the end of a busy period
    p_done_after_busy_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    // R7: a select is held for at least two clocks
    p_min_len_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(&ext_cs_n) |-> (low_len >= 6'd2));

endmodule

bind xbus_select_ctrl xbs_checker i_xbs_checker (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .done     (done),
    .ext_addr (ext_addr),
    .ext_cs_n (ext_cs_n),
    .ext_rd_n (ext_rd_n),
    .ext_wr_n (ext_wr_n)
);

// File: tb/test_xbus_select_ctrl.sv
module test_xbus_select_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_half = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [15:0] rd_data;
    logic [23:0] ext_addr;
    logic [7:0]  ext_cs_n;
    logic        ext_rd_n;
    logic [1:0]  ext_wr_n;
    logic [15:0] ext_dout;
    logic [15:0] ext_din = '0;
    logic        ext_rdy = 1'b1;

    int n_cmp = 0;
    int n_bad = 0;

    // results of the last access
    int          r_len;
    logic [7:0]  r_cs;
    logic [1:0]  r_lanes;
    logic        r_rd;
    logic        r_multi;
    logic [15:0] r_dout;
    logic        r_done;

    always #4 clk = ~clk;

    xbus_select_ctrl i_xbus_select_ctrl (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input int idx, input logic en, input logic wide,
                             input logic [3:0] w, input logic [7:0] mask, input logic [7:0] base);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 3'(idx);
        cfg_wdata = {en, 6'd0, wide, 4'd0, w, mask, base};
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic access(input logic [23:0] a, input logic wr, input logic half,
                          input logic [15:0] wd, input int hold);
        int guard;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_write = wr;
        req_half  = half;
        req_wdata = wd;
        ext_rdy   = (hold == 0);
        @(negedge clk);
        req_valid = 1'b0;
        r_len = 0; r_cs = 8'hff; r_lanes = 2'b00; r_rd = 1'b0; r_multi = 1'b0; r_dout = '0;
        guard = 0;
        while (busy && guard < 200) begin
            r_len++;
            r_cs = r_cs & ext_cs_n;
            if ($countones(~ext_cs_n) > 1) r_multi = 1'b1;
            r_lanes = r_lanes | ~ext_wr_n;
            if (!ext_rd_n) r_rd = 1'b1;
            if (ext_wr_n != 2'b11) r_dout = ext_dout;
            ext_rdy = (r_len > hold);
            @(negedge clk);
            guard++;
        end
        r_done  = done;
        ext_rdy = 1'b1;
    endtask

    task automatic t_reset;
        check("R1 cs_n", ext_cs_n, 8'hff);
        check("R1 rd_n", ext_rd_n, 1'b1);
        check("R1 wr_n", ext_wr_n, 2'b11);
        check("R1 busy/done", {busy, done}, 2'b00);
        for (int i = 0; i < 8; i++) begin
            cfg_idx = 3'(i);
            #1;
            check("R1 cfg zero", cfg_rdata, 32'h0);
        end
    endtask

    task automatic t_config;
        cfg_write(0, 1, 1, 4'd0, 8'h0f, 8'h10);
        cfg_write(1, 1, 0, 4'd3, 8'h00, 8'h20);
        cfg_write(2, 1, 1, 4'd5, 8'h00, 8'h10);
        cfg_write(3, 0, 1, 4'd0, 8'h00, 8'h40);
        cfg_write(7, 1, 1, 4'd1, 8'h7f, 8'h80);
        cfg_idx = 3'd1; #1;
        check("R2 readback idx1", cfg_rdata, 32'h8003_0020);
        cfg_idx = 3'd7; #1;
        check("R2 readback idx7", cfg_rdata, 32'h8101_7f80);
        cfg_idx = 3'd3; #1;
        check("R2 readback idx3", cfg_rdata, 32'h0100_0040);
    endtask

    task automatic t_decode;
        access(24'h1F_0000, 0, 1, 16'h0, 0);
        check("R3 cs window0", r_cs, 8'hfe);
        check("R7 base length", r_len, 2);
        check("R7 done pulse", r_done, 1'b1);
        check("R13 single select", r_multi, 1'b0);
        access(24'h20_1234, 0, 1, 16'h0, 0);
        check("R3 cs window1", r_cs, 8'hfd);
        access(24'h9A_0000, 0, 1, 16'h0, 0);
        check("R3 cs window7", r_cs, 8'h7f);
        check("R8 length w=1", r_len, 3);
    endtask

    task automatic t_priority;
        access(24'h10_0000, 0, 1, 16'h0, 0);
        check("R4 lowest wins", r_cs, 8'hfe);
        check("R4 length of winner", r_len, 2);
        check("R13 single select overlap", r_multi, 1'b0);
    endtask

    task automatic t_disabled;
        access(24'h40_0000, 0, 1, 16'h0, 0);
        check("R5 disabled no select", r_cs, 8'hff);
        cfg_write(3, 1, 1, 4'd0, 8'h00, 8'h40);
        access(24'h40_0000, 0, 1, 16'h0, 0);
        check("R5 enabled selects", r_cs, 8'hf7);
    endtask

    task automatic t_unmatched;
        ext_din = 16'h7777;
        access(24'h21_0000, 0, 1, 16'h0, 10);
        check("R6 no select", r_cs, 8'hff);
        check("R6 two clocks despite ready low", r_len, 2);
        check("R6 no strobe", {r_rd, r_lanes}, 3'b000);
        check("R6 read zero", rd_data, 16'h0);
        check("R6 done", r_done, 1'b1);
    endtask

    task automatic t_waits;
        access(24'h20_0000, 0, 1, 16'h0, 0);
        check("R8 length w=3", r_len, 5);
        cfg_write(1, 1, 0, 4'd15, 8'h00, 8'h20);
        access(24'h20_0000, 0, 1, 16'h0, 0);
        check("R8 length w=15", r_len, 17);
        cfg_write(1, 1, 0, 4'd3, 8'h00, 8'h20);
    endtask

    task automatic t_ready;
        access(24'h20_0000, 0, 1, 16'h0, 3);
        check("R9 ready low during waits ignored", r_len, 5);
        access(24'h20_0000, 0, 1, 16'h0, 8);
        check("R9 ready stretches", r_len, 9);
        access(24'h10_0000, 0, 1, 16'h0, 4);
        check("R9 zero waits stretched", r_len, 5);
    endtask

    task automatic t_lanes;
        access(24'h10_0000, 1, 0, 16'h12AB, 0);
        check("R10 even byte lane", r_lanes, 2'b01);
        check("R10 byte replicated", r_dout, 16'hABAB);
        access(24'h10_0001, 1, 0, 16'h12AB, 0);
        check("R10 odd byte lane", r_lanes, 2'b10);
        access(24'h10_0002, 1, 1, 16'h12AB, 0);
        check("R10 half lanes", r_lanes, 2'b11);
        check("R10 half data", r_dout, 16'h12AB);
        check("R10 no read strobe", r_rd, 1'b0);
    endtask

    task automatic t_narrow;
        access(24'h20_0000, 1, 1, 16'h5566, 0);
        check("R11 narrow lane", r_lanes, 2'b01);
        check("R11 narrow data", r_dout, 16'h6666);
        ext_din = 16'hC3A5;
        access(24'h20_0001, 0, 1, 16'h0, 0);
        check("R11 narrow read", rd_data, 16'h00A5);
    endtask

    task automatic t_read;
        ext_din = 16'hBEEF;
        access(24'h10_0000, 0, 1, 16'h0, 0);
        check("R12 half read", rd_data, 16'hBEEF);
        check("R12 strobes", {r_rd, r_lanes}, 3'b100);
        access(24'h10_0001, 0, 0, 16'h0, 0);
        check("R12 odd byte read", rd_data, 16'h00BE);
        access(24'h10_0000, 0, 0, 16'h0, 0);
        check("R12 even byte read", rd_data, 16'h00EF);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_config();
        t_decode();
        t_priority();
        t_disabled();
        t_unmatched();
        t_waits();
        t_ready();
        t_lanes();
        t_narrow();
        t_read();
        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 50000, 0);
        summary();
    end

endmodule